// File: doc/BRIEF.md
# UART Receive Character Queue with Automatic Flow Control

This block sits between a UART receiver's shift register and the software-facing register interface. Each character the receiver completes is pushed into a first-in first-out store. The three error indications for that character (parity error, framing error, line break) are pushed with it. Software sees the oldest character and its own error flags at the head, and removes characters one at a time with a read strobe. The block also reports the fill level, a data-ready indication and a sticky overrun flag.

The active-low request-to-send output is driven by the hardware from the fill level. It goes high (negated) while the queue holds more characters than a threshold, which a 2-bit select picks from four values. A clear pulse empties the receive queue on its own, drops the overrun flag and brings request-to-send back low.

Top module: `uart_rxq`

## Requirements
- R1: Characters leave in the order they arrived, and `head_data_o` shows the oldest stored character.
- R2: `head_perr_o`, `head_ferr_o` and `head_brk_o` are the flags written with the character now at the head, and all three read 0 while the queue is empty.
- R3: `level_o` gives the number of stored characters, from 0 up to DEPTH (16 by default). The queue is full at DEPTH.
- R4: `ready_o` is 1 exactly when `level_o` is non-zero.
- R5: A read strobe on an empty queue changes nothing: the level stays 0 and no flag is set.
- R6: A write on a full queue with no read in the same cycle is dropped, and the stored characters are unchanged. `overrun_o` becomes 1 after that clock edge.
- R7: `overrun_o` stays 1 until a status-read strobe (`stat_rd_i`) or a clear. If a new overrun and a status read happen in the same cycle, the flag stays 1.
- R8: A write and a read in the same cycle on a full queue are both accepted. The level stays at DEPTH and no overrun is raised.
- R9: `rts_n_o` is 1 while `level_o` is greater than the selected threshold, and 0 otherwise. `thr_sel_i` selects the threshold: 0 gives DEPTH-8, 1 gives DEPTH-5, 2 gives DEPTH-3, 3 gives DEPTH-1 (8, 11, 13 and 15 at the default depth).
- R10: When `clr_i` is sampled high, the queue is empty after that edge, `overrun_o` is 0 and `rts_n_o` is 0. A write or read in the same cycle is ignored.
- R11: After reset the level is 0, `ready_o`, `overrun_o` and `rts_n_o` are 0, and the head outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | A character is available from the receiver |
| wr_data_i | input | DATA_W | Received character |
| wr_perr_i | input | 1 | Parity error flag of the incoming character |
| wr_ferr_i | input | 1 | Framing error flag of the incoming character |
| wr_brk_i | input | 1 | Break flag of the incoming character |
| rd_en_i | input | 1 | Software removes the head character |
| stat_rd_i | input | 1 | Software status read; clears the overrun flag |
| clr_i | input | 1 | Empties the receive queue |
| thr_sel_i | input | 2 | Flow-control threshold select |
| head_data_o | output | DATA_W | Character at the head |
| head_perr_o | output | 1 | Parity error flag of the head character |
| head_ferr_o | output | 1 | Framing error flag of the head character |
| head_brk_o | output | 1 | Break flag of the head character |
| level_o | output | $clog2(DEPTH+1) | Number of stored characters |
| ready_o | output | 1 | At least one character is stored |
| overrun_o | output | 1 | Sticky overrun flag |
| rts_n_o | output | 1 | Request to send, active low |

## Verification
The bench builds the block with its defaults: DATA_W of 8 and DEPTH of 16. At DEPTH 16 the four thresholds are 8, 11, 13 and 15, so one fill of the queue, done once for each threshold select, crosses every threshold and reaches the full state. With only sixteen entries, the dropped-write case, the simultaneous write and read on a full queue, and the pointer wrap-around all come within a few dozen cycles.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rxq_flags_t;

   localparam int unsigned FLAG_W = $bits(rxq_flags_t);

   // Margin below DEPTH for each threshold select value
   function automatic int unsigned thr_margin(input logic [1:0] sel);
      case (sel)
         2'd0:    return 8;
         2'd1:    return 5;
         2'd2:    return 3;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
   parameter int unsigned ENT_W = 11,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             flush_i,
   input  logic [ENT_W-1:0] push_ent_i,
   output logic [ENT_W-1:0] head_ent_o,
   output logic [CW-1:0]    count_o
);

   logic [ENT_W-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[e] <= '0;
         else if (push_i && (wr_ptr == AW'(e)))
            mem[e] <= push_ent_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop_i)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({push_i, pop_i})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_ent_o = (count == '0) ? '0 : mem[rd_ptr];
   assign count_o    = count;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && !pop_i && !flush_i) |=> count == CW'(DEPTH));

   assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> count == '0);

   assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !push_i) |=> count == '0);

endmodule

// File: rtl/uart_rxq_flow.sv
module uart_rxq_flow #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count_i,
   input  logic [1:0]    sel_i,
   output logic          rts_n_o
);
   import uart_rxq_pkg::*;

   logic [CW-1:0] thr;

   always_comb thr = CW'(DEPTH - thr_margin(sel_i));

   assign rts_n_o = (count_i > thr);

   assert_rts_low_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i == '0) |-> !rts_n_o);

   assert_rts_high_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count_i == CW'(DEPTH)) |-> rts_n_o);

endmodule

// File: rtl/uart_rxq_ovr.sv
module uart_rxq_ovr (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   input  logic flush_i,
   output logic ovr_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_o <= 1'b0;
      else if (flush_i) ovr_o <= 1'b0;
      else if (set_i)   ovr_o <= 1'b1;
      else if (ack_i)   ovr_o <= 1'b0;
   end

   assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && !ack_i && !flush_i) |=> ovr_o);

   assert_ovr_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !ovr_o);

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CW    = $clog2(DEPTH + 1),
   localparam int unsigned ENT_W = DATA_W + uart_rxq_pkg::FLAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_perr_i,
   input  logic              wr_ferr_i,
   input  logic              wr_brk_i,
   input  logic              rd_en_i,
   input  logic              stat_rd_i,
   input  logic              clr_i,
   input  logic [1:0]        thr_sel_i,
   output logic [DATA_W-1:0] head_data_o,
   output logic              head_perr_o,
   output logic              head_ferr_o,
   output logic              head_brk_o,
   output logic [CW-1:0]     level_o,
   output logic              ready_o,
   output logic              overrun_o,
   output logic              rts_n_o
);
   import uart_rxq_pkg::*;

   if (DEPTH < 9) begin : g_bad_depth
      $error("uart_rxq: DEPTH must be at least 9 for the threshold set");
   end
   if ((1 << $clog2(DEPTH)) != DEPTH) begin : g_bad_pow2
      $error("uart_rxq: DEPTH must be a power of two");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_rxq: DATA_W must be 5 to 9");
   end

   rxq_flags_t       in_flags, hd_flags;
   logic [ENT_W-1:0] in_ent, hd_ent;
   logic             full, push, pop, ovr_set;

   assign in_flags = '{brk: wr_brk_i, ferr: wr_ferr_i, perr: wr_perr_i};
   assign in_ent   = {in_flags, wr_data_i};

   assign full    = (level_o == CW'(DEPTH));
   assign pop     = rd_en_i && !clr_i && ready_o;
   assign push    = wr_en_i && !clr_i && (!full || pop);
   assign ovr_set = wr_en_i && !clr_i && full && !pop;

   uart_rxq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .pop_i      (pop),
      .flush_i    (clr_i),
      .push_ent_i (in_ent),
      .head_ent_o (hd_ent),
      .count_o    (level_o)
   );

   uart_rxq_flow #(.DEPTH(DEPTH)) flow_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (level_o),
      .sel_i   (thr_sel_i),
      .rts_n_o (rts_n_o)
   );

   uart_rxq_ovr ovr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ovr_set),
      .ack_i   (stat_rd_i),
      .flush_i (clr_i),
      .ovr_o   (overrun_o)
   );

   assign ready_o     = (level_o != '0);
   assign head_data_o = hd_ent[DATA_W-1:0];
   assign hd_flags    = rxq_flags_t'(hd_ent[ENT_W-1:DATA_W]);
   assign head_perr_o = hd_flags.perr;
   assign head_ferr_o = hd_flags.ferr;
   assign head_brk_o  = hd_flags.brk;

   assert_ovr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> $past(wr_en_i && !rd_en_i && level_o == CW'(DEPTH)));

   assert_full_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en_i && rd_en_i && !clr_i && !overrun_o) |=> (level_o == CW'(DEPTH) && !overrun_o));

   assert_empty_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> !(head_perr_o || head_ferr_o || head_brk_o));

endmodule

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;

   localparam int DW = 8;
   localparam int DP = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 0, rd_en = 0, stat_rd = 0, clr = 0;
   logic [DW-1:0] wr_data = '0;
   logic [2:0]    wr_flg = '0;
   logic [1:0]    thr_sel = '0;
   logic [DW-1:0] head_data;
   logic          head_perr, head_ferr, head_brk;
   logic [4:0]    level;
   logic          ready, overrun, rts_n;

   int total = 0;
   int bad = 0;
   logic [10:0] exp_q[$];
   logic        exp_ovr = 1'b0;

   always #2.5 clk = ~clk;

   uart_rxq #(.DATA_W(DW), .DEPTH(DP)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .wr_perr_i(wr_flg[0]), .wr_ferr_i(wr_flg[1]), .wr_brk_i(wr_flg[2]),
      .rd_en_i(rd_en), .stat_rd_i(stat_rd), .clr_i(clr), .thr_sel_i(thr_sel),
      .head_data_o(head_data), .head_perr_o(head_perr), .head_ferr_o(head_ferr),
      .head_brk_o(head_brk), .level_o(level), .ready_o(ready),
      .overrun_o(overrun), .rts_n_o(rts_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int thr_of(input logic [1:0] s);
      case (s)
         2'd0: return 8;
         2'd1: return 11;
         2'd2: return 13;
         default: return 15;
      endcase
   endfunction

   // Monitor side: compare port state with the scoreboard model
   task automatic check_state();
      chk("R3 level", int'(level), exp_q.size());
      chk("R4 ready", int'(ready), int'(exp_q.size() != 0));
      chk("R7 overrun", int'(overrun), int'(exp_ovr));
      chk("R9 rts_n", int'(rts_n), int'(exp_q.size() > thr_of(thr_sel)));
      if (exp_q.size() == 0)
         chk("R2 empty flags", int'({head_brk, head_ferr, head_perr}), 0);
      else
         chk("R1 R2 head", int'({head_brk, head_ferr, head_perr, head_data}), int'(exp_q[0]));
   endtask

   // Driver: applies one cycle and updates the expected queue
   task automatic step(input logic w, input logic [DW-1:0] d, input logic [2:0] f,
                       input logic r, input logic s, input logic c);
      bit full, do_rd, set;
      wr_en = w; wr_data = d; wr_flg = f; rd_en = r; stat_rd = s; clr = c;
      #1;
      if (r && !c && exp_q.size() != 0)
         chk("R1 R2 popped", int'({head_brk, head_ferr, head_perr, head_data}), int'(exp_q[0]));
      @(posedge clk);
      if (c) begin
         exp_q.delete();
         exp_ovr = 1'b0;
      end else begin
         full  = (exp_q.size() == DP);
         do_rd = r && exp_q.size() != 0;
         set   = w && full && !do_rd;
         if (do_rd) void'(exp_q.pop_front());
         if (w && (!full || do_rd)) exp_q.push_back({f, d});
         if (set) exp_ovr = 1'b1;
         else if (s) exp_ovr = 1'b0;
      end
      @(negedge clk);
      wr_en = 0; rd_en = 0; stat_rd = 0; clr = 0;
      check_state();
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk("watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 level", int'(level), 0);
      chk("R11 flags", int'({ready, overrun, rts_n}), 0);
      chk("R11 head", int'({head_brk, head_ferr, head_perr, head_data}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 a few characters with different flags
      step(1, 8'h41, 3'b001, 0, 0, 0);
      step(1, 8'h5A, 3'b010, 0, 0, 0);
      step(1, 8'hC3, 3'b100, 0, 0, 0);
      step(1, 8'h00, 3'b111, 1, 0, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);

      // R5 read on empty
      step(0, 0, 0, 1, 0, 0);
      chk("R5 empty read level", int'(level), 0);
      chk("R5 empty read overrun", int'(overrun), 0);

      // R9 fill with each threshold select
      for (int s = 0; s < 4; s++) begin
         thr_sel = 2'(s);
         for (int i = 0; i < DP; i++) step(1, 8'(i * 7 + s), 3'(i), 0, 0, 0);
         chk("R9 rts at full", int'(rts_n), 1);
         if (s < 3) step(0, 0, 0, 0, 0, 1);
      end

      // R6 write on full is dropped
      step(1, 8'hEE, 3'b111, 0, 0, 0);
      chk("R6 level after drop", int'(level), DP);
      chk("R6 overrun set", int'(overrun), 1);
      // R7 sticky, then cleared by status read
      step(0, 0, 0, 0, 0, 0);
      chk("R7 still set", int'(overrun), 1);
      step(1, 8'hEF, 3'b000, 0, 1, 0);
      chk("R7 set wins over status read", int'(overrun), 1);
      step(0, 0, 0, 0, 1, 0);
      chk("R7 cleared by status read", int'(overrun), 0);

      // R8 write and read together on full
      step(1, 8'h77, 3'b101, 1, 0, 0);
      chk("R8 level", int'(level), DP);
      chk("R8 no overrun", int'(overrun), 0);

      // drain through the wrap point
      for (int i = 0; i < DP; i++) step(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) step(1, 8'(8'h90 + i), 3'(i), (i > 1), 0, 0);

      // R10 clear with concurrent write and read
      thr_sel = 2'd0;
      for (int i = 0; i < 12; i++) step(1, 8'(i), 3'b000, 0, 0, 0);
      step(1, 8'hAA, 3'b000, 0, 0, 0);
      step(1, 8'hAB, 3'b010, 1, 0, 1);
      chk("R10 level", int'(level), 0);
      chk("R10 rts_n", int'(rts_n), 0);
      chk("R10 ready", int'(ready), 0);
      step(1, 8'h3C, 3'b001, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule